// File: doc/BRIEF.md
# Indexed Effective-Address Sequencer

This block works out the operand address for a small 8-bit accumulator processor with a 16-bit address space. A pulse on `start` comes with an addressing-mode code, an access kind and the current index registers. The sequencer then issues one bus access per clock. These are fetches of address bytes at the program counter, pointer reads in page zero, and the dummy reads the processor makes while it fixes up an address. It ends with a one-clock `done` pulse that carries the 16-bit effective address. The operand access and the data operation that follow belong to the surrounding core.

The program counter lives outside the block. `pc_inc` asks the owner to advance it by one at the end of that clock. `rdata` is sampled at the clock edge that ends each read cycle. Index arithmetic in page zero wraps within the page. An indexed absolute or post-indexed address is first formed without the carry into the high byte. When an access only reads, the fix-up cycle is inserted only if that carry occurs. When an access writes or modifies, the fix-up cycle always occurs.

Top module: `ea_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `rd_en`, `pc_inc` and `done` are all low.
- R2: Mode 0 (immediate) makes no bus read. `done` rises in the first clock after `start`, with `ea` equal to the PC at `start` and `pc_inc` high.
- R3: Mode 1 (page zero) reads one byte at PC with `pc_inc`. The next clock gives `done` with `ea` = {0x00, byte}.
- R4: Modes 2 (page zero + X) and 3 (page zero + Y) fetch the base at PC, then make a dummy read at {0x00, base}. `ea` = {0x00, (base + index) mod 256}.
- R5: Mode 4 (absolute) reads the low byte at PC and the high byte at PC+1, with `pc_inc` in both cycles. It never adds a fix-up cycle, even for writes. `ea` = {high, low}.
- R6: Modes 5 (absolute + X), 6 (absolute + Y) and 8 (post-indexed by Y) give `done` right after the last address-byte read when the access is a pure read (`wr_kind` = 0) and low + index < 256.
- R7: In modes 5, 6 and 8 on a pure read where low + index carries, one dummy read at {high, (low + index) mod 256} comes before `done`. `ea` = {(high + 1) mod 256, (low + index) mod 256}.
- R8: In modes 5, 6 and 8 with `wr_kind` = 1, the dummy read at {high, (low + index) mod 256} always occurs, whether or not there is a carry.
- R9: Mode 7 (pre-indexed by X) fetches ptr at PC and makes a dummy read at {0x00, ptr}. It then reads the low byte at {0x00, (ptr+X) mod 256} and the high byte at {0x00, (ptr+X+1) mod 256}, with no fix-up cycle.
- R10: Mode 8 fetches ptr at PC, then reads the low byte at {0x00, ptr} and the high byte at {0x00, (ptr+1) mod 256}. Y is added to the low byte.
- R11: `done` lasts one clock. A `start` given in the `done` clock is accepted, so sequences can run back to back.
- R12: A `start` given while a sequence is running is ignored, and the running sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted when idle or in the `done` clock) |
| mode | input | 4 | Addressing mode code 0..8 |
| wr_kind | input | 1 | 1 = write or read-modify-write access, 0 = pure read |
| idx_x | input | 8 | X index, sampled at start |
| idx_y | input | 8 | Y index, sampled at start |
| pc | input | 16 | Current program counter |
| rdata | input | 8 | Read data for the current bus cycle |
| bus_addr | output | 16 | Address of the current bus read |
| rd_en | output | 1 | A bus read happens this clock |
| pc_inc | output | 1 | Advance PC at the end of this clock |
| ea | output | 16 | Effective address, valid with `done` |
| done | output | 1 | One-clock completion pulse |

## Verification
`start` is sampled at a clock edge. The first bus cycle, or `done` for an immediate, appears in the clock that follows that edge. Each later bus cycle appears one clock after the previous one, and `done` comes one clock after the last bus read. The bench models memory and the PC, and writes out the full expected list of cycles for a request before it pulses `start`. Every clock, 2 ns after the edge, the monitor takes the next expected cycle and compares strobes, bus address and effective address. So any extra, missing or shifted dummy read shows up as a miscompare in that exact cycle.

// File: rtl/ea_seq.sv
module ea_seq #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic          wr_kind,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          rd_en,
  output logic          pc_inc,
  output logic [AW-1:0] ea,
  output logic          done
);
  localparam int HW = AW - DW;
  localparam logic [3:0] M_IMM = 4'd0, M_ZP = 4'd1, M_ZPX = 4'd2, M_ZPY = 4'd3,
                         M_ABS = 4'd4, M_ABX = 4'd5, M_ABY = 4'd6, M_INX = 4'd7,
                         M_IDY = 4'd8;

  typedef enum logic [2:0] {
    S_IDLE, S_OP1, S_OP2, S_ZDUM, S_PLO, S_PHI, S_FIX, S_FIN
  } st_t;

  st_t           st;
  logic [3:0]    md;
  logic          wr_q;
  logic [DW-1:0] idx, b, lo;
  logic [HW-1:0] hi;
  logic          cy;

  wire          take     = start && (st == S_IDLE || st == S_FIN);
  wire [DW:0]   sum_lo   = {1'b0, rdata} + {1'b0, idx};
  wire          post_idx = (md == M_ABX) || (md == M_ABY) || (md == M_IDY);
  wire          need_fix = post_idx && (cy || wr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      md   <= M_IMM;
      wr_q <= 1'b0;
      idx  <= '0;
      b    <= '0;
      lo   <= '0;
      hi   <= '0;
      cy   <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_FIN: begin
          if (take) begin
            md   <= mode;
            wr_q <= wr_kind;
            cy   <= 1'b0;
            case (mode)
              M_ZPX, M_ABX, M_INX: idx <= idx_x;
              M_ZPY, M_ABY, M_IDY: idx <= idx_y;
              default:             idx <= '0;
            endcase
            if (mode == M_IMM) begin
              hi <= pc[AW-1:DW];
              lo <= pc[DW-1:0];
              st <= S_FIN;
            end else begin
              hi <= '0;
              lo <= '0;
              st <= S_OP1;
            end
          end else begin
            st <= S_IDLE;
          end
        end
        S_OP1: begin
          b <= rdata;
          case (md)
            M_ZP: begin
              lo <= rdata;
              st <= S_FIN;
            end
            M_ZPX, M_ZPY, M_INX: st <= S_ZDUM;
            M_ABS, M_ABX, M_ABY: begin
              {cy, lo} <= sum_lo;
              st       <= S_OP2;
            end
            M_IDY:   st <= S_PLO;
            default: st <= S_FIN;
          endcase
        end
        S_OP2: begin
          hi <= rdata;
          st <= need_fix ? S_FIX : S_FIN;
        end
        S_ZDUM: begin
          if (md == M_INX) begin
            b  <= b + idx;
            st <= S_PLO;
          end else begin
            lo <= b + idx;
            st <= S_FIN;
          end
        end
        S_PLO: begin
          if (md == M_INX) {cy, lo} <= {1'b0, rdata};
          else             {cy, lo} <= sum_lo;
          b  <= b + 1'b1;
          st <= S_PHI;
        end
        S_PHI: begin
          hi <= rdata;
          st <= need_fix ? S_FIX : S_FIN;
        end
        S_FIX:   st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire fetch_pc = (st == S_OP1) || (st == S_OP2);
  wire zp_cycle = (st == S_ZDUM) || (st == S_PLO) || (st == S_PHI);

  assign rd_en    = fetch_pc || zp_cycle || (st == S_FIX);
  assign pc_inc   = fetch_pc || (st == S_FIN && md == M_IMM);
  assign bus_addr = fetch_pc        ? pc :
                    zp_cycle        ? {{HW{1'b0}}, b} :
                    (st == S_FIX)   ? {hi, lo} : '0;
  assign done     = (st == S_FIN);
  assign ea       = {hi + {{(HW-1){1'b0}}, cy}, lo};

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  // R7 R8
  fix_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == S_FIX) |=> done && ea[DW-1:0] == $past(bus_addr[DW-1:0]));

  // R6
  no_penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OP2 || st == S_PHI) && !wr_q && !cy |=> done);

  // R4
  zp_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (md == M_ZP || md == M_ZPX || md == M_ZPY) |-> ea[AW-1:DW] == '0);

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && rd_en |=> $stable(md) && $stable(wr_q));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !rd_en && !pc_inc && !done);
endmodule

// File: tb/sim_ea_seq.sv
module sim_ea_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        wr_kind = 1'b0;
  logic [7:0]  idx_x = 8'd0, idx_y = 8'd0;
  logic [15:0] pc = 16'd0;
  logic [7:0]  rdata = 8'd0;
  logic [15:0] bus_addr, ea;
  logic        rd_en, pc_inc, done;

  logic        pc_ld = 1'b0;
  logic [15:0] pc_val = 16'd0;

  int n_chk = 0, n_bad = 0, pending = 0;

  logic        q_rd[$], q_pci[$], q_done[$];
  logic [15:0] q_addr[$], q_ea[$];
  string       q_tag[$];

  logic [15:0] ov_a[16];
  logic [7:0]  ov_d[16];
  int          ov_n = 0;

  always #5 clk = ~clk;

  ea_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wr_kind(wr_kind),
    .idx_x(idx_x), .idx_y(idx_y), .pc(pc), .rdata(rdata),
    .bus_addr(bus_addr), .rd_en(rd_en), .pc_inc(pc_inc), .ea(ea), .done(done)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] v;
    v = a[7:0] ^ a[15:8] ^ 8'h96;
    for (int i = 0; i < ov_n; i++) if (ov_a[i] == a) v = ov_d[i];
    return v;
  endfunction

  task automatic poke(input logic [15:0] a, input logic [7:0] d);
    ov_a[ov_n] = a;
    ov_d[ov_n] = d;
    ov_n++;
  endtask

  always @(posedge clk) begin
    if (pc_ld) pc <= pc_val;
    else if (pc_inc) pc <= pc + 16'd1;
  end

  always @(negedge clk) rdata = memf(bus_addr);

  task automatic exp(input logic r, input logic p, input logic [15:0] a,
                     input logic d, input logic [15:0] e, input string t);
    q_rd.push_back(r);
    q_pci.push_back(p);
    q_addr.push_back(a);
    q_done.push_back(d);
    q_ea.push_back(e);
    q_tag.push_back(t);
    pending++;
  endtask

  task automatic go(input logic [3:0] m, input logic w, input logic [7:0] x,
                    input logic [7:0] y, input logic [15:0] pc0, input bit ld,
                    input string t);
    logic [7:0] b, lo, hi, q, q1, ix;
    logic [8:0] s;
    if (ld) begin
      pc_ld  = 1'b1;
      pc_val = pc0;
      @(negedge clk);
      pc_ld  = 1'b0;
    end
    ix = (m == 4'd2 || m == 4'd5 || m == 4'd7) ? x : y;
    case (m)
      4'd0: exp(1'b0, 1'b1, 16'h0, 1'b1, pc0, t);
      4'd1: begin
        b = memf(pc0);
        exp(1'b1, 1'b1, pc0, 1'b0, 16'h0, t);
        exp(1'b0, 1'b0, 16'h0, 1'b1, {8'h00, b}, t);
      end
      4'd2, 4'd3: begin
        b = memf(pc0);
        exp(1'b1, 1'b1, pc0, 1'b0, 16'h0, t);
        exp(1'b1, 1'b0, {8'h00, b}, 1'b0, 16'h0, t);
        q = b + ix;
        exp(1'b0, 1'b0, 16'h0, 1'b1, {8'h00, q}, t);
      end
      4'd4, 4'd5, 4'd6: begin
        lo = memf(pc0);
        hi = memf(pc0 + 16'd1);
        exp(1'b1, 1'b1, pc0, 1'b0, 16'h0, t);
        exp(1'b1, 1'b1, pc0 + 16'd1, 1'b0, 16'h0, t);
        s = {1'b0, lo} + {1'b0, (m == 4'd4) ? 8'h00 : ix};
        if (m != 4'd4 && (s[8] || w)) exp(1'b1, 1'b0, {hi, s[7:0]}, 1'b0, 16'h0, t);
        exp(1'b0, 1'b0, 16'h0, 1'b1, {hi + {7'd0, s[8]}, s[7:0]}, t);
      end
      4'd7: begin
        b = memf(pc0);
        exp(1'b1, 1'b1, pc0, 1'b0, 16'h0, t);
        exp(1'b1, 1'b0, {8'h00, b}, 1'b0, 16'h0, t);
        q  = b + x;
        q1 = q + 8'd1;
        lo = memf({8'h00, q});
        hi = memf({8'h00, q1});
        exp(1'b1, 1'b0, {8'h00, q}, 1'b0, 16'h0, t);
        exp(1'b1, 1'b0, {8'h00, q1}, 1'b0, 16'h0, t);
        exp(1'b0, 1'b0, 16'h0, 1'b1, {hi, lo}, t);
      end
      default: begin
        b  = memf(pc0);
        q1 = b + 8'd1;
        lo = memf({8'h00, b});
        hi = memf({8'h00, q1});
        exp(1'b1, 1'b1, pc0, 1'b0, 16'h0, t);
        exp(1'b1, 1'b0, {8'h00, b}, 1'b0, 16'h0, t);
        exp(1'b1, 1'b0, {8'h00, q1}, 1'b0, 16'h0, t);
        s = {1'b0, lo} + {1'b0, y};
        if (s[8] || w) exp(1'b1, 1'b0, {hi, s[7:0]}, 1'b0, 16'h0, t);
        exp(1'b0, 1'b0, 16'h0, 1'b1, {hi + {7'd0, s[8]}, s[7:0]}, t);
      end
    endcase
    mode = m; wr_kind = w; idx_x = x; idx_y = y;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain(input bit gap);
    wait (pending == 0);
    @(negedge clk);
    if (gap) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (pending > 0) begin
          logic er, ep, ed;
          logic [15:0] ea_e, ad_e;
          string t;
          er = q_rd.pop_front(); ep = q_pci.pop_front(); ed = q_done.pop_front();
          ad_e = q_addr.pop_front(); ea_e = q_ea.pop_front(); t = q_tag.pop_front();
          pending--;
          n_chk++;
          if (rd_en !== er || pc_inc !== ep || done !== ed ||
              (er && bus_addr !== ad_e) || (ed && ea !== ea_e)) begin
            n_bad++;
            $display("FAIL %s: got rd=%0b pci=%0b done=%0b addr=%h ea=%h exp rd=%0b pci=%0b done=%0b addr=%h ea=%h",
                     t, rd_en, pc_inc, done, bus_addr, ea, er, ep, ed, ad_e, ea_e);
          end
        end else begin
          n_chk++;
          if (rd_en !== 1'b0 || pc_inc !== 1'b0 || done !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: idle got rd=%0b pci=%0b done=%0b exp 0 0 0", rd_en, pc_inc, done);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    poke(16'h2000, 8'h44);
    poke(16'h2010, 8'hF0); poke(16'h2020, 8'h80);
    poke(16'h3000, 8'h34); poke(16'h3001, 8'h12);
    poke(16'h3100, 8'h10); poke(16'h3101, 8'h40);
    poke(16'h3200, 8'hF0); poke(16'h3201, 8'h40);
    poke(16'h3300, 8'hFF); poke(16'h3301, 8'hFF);
    poke(16'h4000, 8'hFE); poke(16'h4100, 8'hFF);
    poke(16'h00FF, 8'h78); poke(16'h0000, 8'h56);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);             // R1 idle checks after reset

    go(4'd0, 1'b0, 8'h00, 8'h00, 16'h1234, 1'b1, "R2"); drain(1'b1);
    go(4'd1, 1'b0, 8'h00, 8'h00, 16'h2000, 1'b1, "R3"); drain(1'b1);
    go(4'd2, 1'b0, 8'h20, 8'h00, 16'h2010, 1'b1, "R4"); drain(1'b1);
    go(4'd3, 1'b0, 8'h00, 8'h05, 16'h2020, 1'b1, "R4"); drain(1'b1);
    go(4'd4, 1'b0, 8'hFF, 8'hFF, 16'h3000, 1'b1, "R5"); drain(1'b1);
    go(4'd4, 1'b1, 8'hFF, 8'hFF, 16'h3000, 1'b1, "R5"); drain(1'b1);
    go(4'd5, 1'b0, 8'h05, 8'h00, 16'h3100, 1'b1, "R6"); drain(1'b1);
    go(4'd5, 1'b0, 8'h20, 8'h00, 16'h3200, 1'b1, "R7"); drain(1'b1);
    go(4'd6, 1'b0, 8'h00, 8'h01, 16'h3300, 1'b1, "R7"); drain(1'b1);
    go(4'd5, 1'b1, 8'h05, 8'h00, 16'h3100, 1'b1, "R8"); drain(1'b1);
    go(4'd6, 1'b1, 8'h00, 8'h20, 16'h3200, 1'b1, "R8"); drain(1'b1);
    go(4'd7, 1'b0, 8'h01, 8'h00, 16'h4000, 1'b1, "R9"); drain(1'b1);
    go(4'd7, 1'b1, 8'h05, 8'h00, 16'h2020, 1'b1, "R9"); drain(1'b1);
    go(4'd8, 1'b0, 8'h00, 8'h10, 16'h4100, 1'b1, "R10"); drain(1'b1);
    go(4'd8, 1'b0, 8'h00, 8'h90, 16'h4100, 1'b1, "R10"); drain(1'b1);
    go(4'd8, 1'b1, 8'h00, 8'h10, 16'h4100, 1'b1, "R8"); drain(1'b1);

    // R11: next start given in the done clock
    go(4'd1, 1'b0, 8'h00, 8'h00, 16'h2000, 1'b1, "R11"); drain(1'b0);
    go(4'd0, 1'b0, 8'h00, 8'h00, 16'h2001, 1'b0, "R11"); drain(1'b0);
    go(4'd4, 1'b0, 8'h00, 8'h00, 16'h2002, 1'b0, "R11"); drain(1'b1);

    // R12: start pulses while busy must not disturb the sequence
    go(4'd5, 1'b0, 8'h20, 8'h00, 16'h3200, 1'b1, "R12");
    mode = 4'd0; start = 1'b1;
    @(negedge clk);
    mode = 4'd1;
    @(negedge clk);
    start = 1'b0;
    drain(1'b1);
    repeat (2) @(negedge clk);

    summary();
    $finish;
  end
endmodule